// File: doc/BRIEF.md
# Pseudo-SRAM Asynchronous Write Sequencer

This block sits between a synchronous system bus and a 16-bit pseudo-SRAM driven in its asynchronous mode. A request carries a word address, a data word and two byte enables. The sequencer accepts one write at a time through a valid/ready handshake. It then generates the chip-select, write-enable and byte-strobe waveform that the memory needs, and it drives the shared data bus for the duration of the write.

The memory's nanosecond minimums are parameters. They are turned into whole clock cycles by rounding up against the clock period. The write window is held open for the longest of the cycle counts that bound the end of write: chip-select width, address-to-end, strobe-to-end, data setup and pulse width. The next request is held off until the full cycle time has passed. A run counter tracks back-to-back writes. Once a run grows past a parameterised length, the longer pulse minimum that the memory needs for sustained writing is applied.

Output enable is held inactive at all times. Reads, burst mode and the memory's wait output play no part.

Top module: `psram_write_seq`

## Requirements
- R1: After reset, mem_cs_n, mem_we_n, mem_ub_n and mem_lb_n are high, req_ready is high, and no write is in progress.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both high. From the next cycle, mem_cs_n is low and mem_addr holds the accepted address. mem_addr stays unchanged for as long as mem_cs_n stays low.
- R3: At the default 20 ns clock, a normal write holds mem_we_n and mem_cs_n low together for exactly 3 cycles, starting in the cycle after acceptance. Both signals rise on the same edge.
- R4: req_be[1] selects the upper byte (data bits 15:8) through mem_ub_n, and req_be[0] selects the lower byte (bits 7:0) through mem_lb_n. An enabled strobe is low in exactly the cycles in which mem_we_n is low.
- R5: A request with req_be equal to 2'b00 is accepted and runs a full cycle with mem_cs_n low. mem_we_n and both strobes stay high throughout, and no memory byte changes.
- R6: mem_dq carries the accepted data from the first cycle with mem_cs_n low through the cycle after mem_we_n rises.
- R7: req_ready is low while mem_we_n is low. At default settings, consecutive accepts of normal writes are at least 4 cycles apart, and accepts of lengthened writes are at least 5 cycles apart.
- R8: A run count rises by one on each accept. It returns to zero on any cycle where req_ready is high and req_valid is low. From the 51st write of a run onward, the pulse is 4 cycles and the cycle is 5 cycles at default settings.
- R9: mem_oe_n is high in every cycle.
- R10: After any sequence of writes, the memory holds the data of the last write to each byte whose lane was enabled. No other byte is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer can take a request this cycle |
| req_addr | input | 22 | Word address |
| req_data | input | 16 | Write data |
| req_be | input | 2 | Byte enables: bit 1 upper, bit 0 lower |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, held high |
| mem_addr | output | 22 | Memory address |
| mem_dq | inout | 16 | Memory data bus, driven only during writes |

## Verification
Every memory pin changes on the edge that accepts a request, so the bench expects chip select, the strobes, write enable and the data bus one cycle after the accepting edge. The window then closes exactly pulse-length cycles later, and ready comes back in the cycle-length minus one cycle after acceptance. A behavioural model advances on each rising edge from the bench's own view of the handshake and predicts these pins. The pins are compared against it on every falling edge, which keeps each comparison half a cycle clear of the edge that changed them. The memory contents are gathered from the write-enable rising edges that were observed, and are compared at the end against the byte-lane writes the bench expected.

// File: rtl/psram_write_seq.sv
module psram_write_seq #(
  parameter int ADDR_W      = 22,
  parameter int DATA_W      = 16,
  parameter int CLK_NS      = 20,
  parameter int T_WC_NS     = 70,
  parameter int T_CW_NS     = 60,
  parameter int T_AW_NS     = 60,
  parameter int T_BW_NS     = 60,
  parameter int T_WP_NS     = 55,
  parameter int T_WP_RUN_NS = 70,
  parameter int T_DW_NS     = 30,
  parameter int RUN_LIMIT   = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [1:0]        req_be,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq
);

  function automatic int cyc(int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int SETUP_CY    = max2(max2(cyc(T_CW_NS), cyc(T_AW_NS)), max2(cyc(T_BW_NS), cyc(T_DW_NS)));
  localparam int PULSE_SHORT = max2(SETUP_CY, cyc(T_WP_NS));
  localparam int PULSE_LONG  = max2(SETUP_CY, cyc(T_WP_RUN_NS));
  localparam int CYC_SHORT   = max2(PULSE_SHORT + 1, cyc(T_WC_NS));
  localparam int CYC_LONG    = max2(PULSE_LONG + 1, cyc(T_WC_NS));
  localparam int CNT_W       = $clog2(CYC_LONG + 1);
  localparam int RUN_W       = $clog2(RUN_LIMIT + 2);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(RUN_LIMIT + 1);

  logic              busy, long_q, dq_en;
  logic [CNT_W-1:0]  cnt;
  logic [RUN_W-1:0]  run;
  logic [DATA_W-1:0] data_q;

  wire [CNT_W-1:0] pulse   = long_q ? CNT_W'(PULSE_LONG) : CNT_W'(PULSE_SHORT);
  wire [CNT_W-1:0] cyc_end = long_q ? CNT_W'(CYC_LONG - 1) : CNT_W'(CYC_SHORT - 1);
  wire             last    = busy && (cnt == cyc_end);
  wire             accept  = req_valid && req_ready;
  wire [RUN_W-1:0] run_nx  = (run == RUN_SAT) ? run : run + 1'b1;

  assign req_ready = !busy || last;
  assign mem_oe_n  = 1'b1;
  assign mem_dq    = dq_en ? data_q : {DATA_W{1'bz}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      long_q   <= 1'b0;
      cnt      <= '0;
      run      <= '0;
      dq_en    <= 1'b0;
      data_q   <= '0;
      mem_addr <= '0;
      mem_cs_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_ub_n <= 1'b1;
      mem_lb_n <= 1'b1;
    end else if (accept) begin
      busy     <= 1'b1;
      long_q   <= (run_nx > RUN_W'(RUN_LIMIT));
      cnt      <= '0;
      run      <= run_nx;
      dq_en    <= 1'b1;
      data_q   <= req_data;
      mem_addr <= req_addr;
      mem_cs_n <= 1'b0;
      mem_we_n <= ~|req_be;
      mem_ub_n <= ~req_be[1];
      mem_lb_n <= ~req_be[0];
    end else begin
      if (req_ready && !req_valid) run <= '0;
      if (busy) cnt <= cnt + 1'b1;
      if (last) busy <= 1'b0;
      if (busy && cnt == pulse - 1'b1) begin
        mem_cs_n <= 1'b1;
        mem_we_n <= 1'b1;
        mem_ub_n <= 1'b1;
        mem_lb_n <= 1'b1;
      end
      if (busy && cnt == pulse) dq_en <= 1'b0;
    end
  end

endmodule

// File: rtl/psram_write_seq_chk.sv
module psram_write_seq_chk #(
  parameter int ADDR_W  = 22,
  parameter int CLK_NS  = 20,
  parameter int T_WP_NS = 55
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_ub_n,
  input logic              mem_lb_n,
  input logic              mem_oe_n,
  input logic [ADDR_W-1:0] mem_addr
);
  localparam int WP_MIN = (T_WP_NS + CLK_NS - 1) / CLK_NS;

  logic [7:0] lo_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_cnt <= '0;
    else if (mem_we_n) lo_cnt <= '0;
    else if (lo_cnt != 8'hff) lo_cnt <= lo_cnt + 1'b1;
  end

  assert_we_inside_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);
  assert_pulse_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (lo_cnt >= 8'(WP_MIN)));
  assert_strobe_needs_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ub_n || !mem_lb_n) |-> !mem_we_n);
  assert_we_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ub_n || !mem_lb_n));
  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
  assert_no_ready_in_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !req_ready);
  assert_oe_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_oe_n);
endmodule

bind psram_write_seq psram_write_seq_chk #(.ADDR_W(ADDR_W), .CLK_NS(CLK_NS), .T_WP_NS(T_WP_NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_cs_n(mem_cs_n),
  .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
  .mem_oe_n(mem_oe_n), .mem_addr(mem_addr)
);

// File: tb/tb_psram_write_seq.sv
module tb_psram_write_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [21:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic [1:0]  req_be = '0;
  logic        mem_cs_n, mem_we_n, mem_ub_n, mem_lb_n, mem_oe_n;
  logic [21:0] mem_addr;
  wire  [15:0] mem_dq;

  always #10 clk = ~clk;

  psram_write_seq dut (.*);

  int tests = 0, fails = 0;
  task automatic chk(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: pulse 3/4, cycle 4/5, long after 50 in a run
  bit          m_busy = 0, m_acc = 0, m_on = 0;
  int          m_k = 0, m_p = 3, m_t = 4, m_run = 0;
  logic [21:0] m_addr;
  logic [15:0] m_data;
  logic [1:0]  m_be;
  logic [7:0]  exp_mem[int];
  logic [7:0]  got_mem[int];

  always @(posedge clk) begin
    bit rdy;
    rdy   = !m_busy || (m_k == m_t - 1);
    m_acc = 0;
    if (rst_n) begin
      if (req_valid && rdy) begin
        m_acc = 1;
        m_run = (m_run < 51) ? m_run + 1 : 51;
        m_p = (m_run > 50) ? 4 : 3;
        m_t = (m_run > 50) ? 5 : 4;
        m_k = 0; m_busy = 1;
        m_addr = req_addr; m_data = req_data; m_be = req_be;
        if (req_be[1]) exp_mem[int'(req_addr) * 2 + 1] = req_data[15:8];
        if (req_be[0]) exp_mem[int'(req_addr) * 2]     = req_data[7:0];
      end else begin
        if (rdy) m_run = 0;
        if (m_busy) begin
          if (m_k == m_t - 1) m_busy = 0;
          else m_k++;
        end
      end
    end
  end

  logic [21:0] l_addr;
  logic [15:0] l_dq;
  logic        l_ub, l_lb, pend = 0;

  always @(negedge clk) begin
    if (m_on) begin
      bit win, drv;
      win = m_busy && m_k < m_p;
      drv = m_busy && m_k <= m_p;
      chk(mem_cs_n == !win, "R2 cs_n", mem_cs_n, !win);
      chk(mem_we_n == !(win && m_be != 0), "R3/R5 we_n", mem_we_n, !(win && m_be != 0));
      chk(mem_ub_n == !(win && m_be[1]), "R4 ub_n", mem_ub_n, !(win && m_be[1]));
      chk(mem_lb_n == !(win && m_be[0]), "R4 lb_n", mem_lb_n, !(win && m_be[0]));
      chk(mem_oe_n == 1'b1, "R9 oe_n", mem_oe_n, 1);
      chk(req_ready == (!m_busy || m_k == m_t - 1), "R7/R8 ready", req_ready, (!m_busy || m_k == m_t - 1));
      if (win) chk(mem_addr == m_addr, "R2 addr", mem_addr, m_addr);
      if (drv) chk(mem_dq == m_data, "R6 dq", mem_dq, m_data);
    end
    if (!mem_we_n) begin
      l_addr = mem_addr; l_dq = mem_dq; l_ub = mem_ub_n; l_lb = mem_lb_n; pend = 1;
    end else if (pend) begin
      pend = 0;
      if (!l_ub) got_mem[int'(l_addr) * 2 + 1] = l_dq[15:8];
      if (!l_lb) got_mem[int'(l_addr) * 2]     = l_dq[7:0];
    end
  end

  task automatic wr(logic [21:0] a, logic [15:0] d, logic [1:0] be, bit keep);
    req_valid = 1; req_addr = a; req_data = d; req_be = be;
    do @(negedge clk); while (!m_acc);
    if (!keep) req_valid = 0;
  endtask

  task automatic idle(int n);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_ub_n && mem_lb_n, "R1 pins in reset", {mem_cs_n, mem_we_n, mem_ub_n, mem_lb_n}, 4'hf);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(mem_cs_n == 1'b1, "R1 cs_n after reset", mem_cs_n, 1);
        m_on = 1;
        wr(22'h00_0010, 16'hA1B2, 2'b11, 0); idle(6);
        wr(22'h00_0011, 16'hC3D4, 2'b10, 0); idle(6);
        wr(22'h00_0012, 16'hE5F6, 2'b01, 0); idle(6);
        wr(22'h00_0013, 16'h1234, 2'b00, 0); idle(6);   // R5
        wr(22'h3F_FFFF, 16'hFFFF, 2'b11, 0); idle(6);
        for (int i = 0; i < 60; i++)                    // R8 long run
          wr(22'(i * 37 + 100), 16'(i * 16'h1111) ^ 16'h5A3C, 2'((i % 3) + 1), 1);
        idle(8);
        wr(22'h00_0010, 16'h0F0F, 2'b01, 1);            // R8 short again after idle
        wr(22'h00_0011, 16'h7788, 2'b00, 0);
        idle(8);
        m_on = 0;
        chk(got_mem.size() == exp_mem.size(), "R10 written byte count", got_mem.size(), exp_mem.size());
        foreach (exp_mem[k])
          chk(got_mem.exists(k) && got_mem[k] == exp_mem[k], "R10 byte content",
              got_mem.exists(k) ? got_mem[k] : 9'h100, exp_mem[k]);
      end
      begin
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule